// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block oversees how a CAN controller climbs back out of the bus-off state. A bus-off event forces the initialization flag to 1, and the controller stays off the bus. The block then waits for software to write the flag back to 0. Only after that write does it watch the sampled receive line. Each time it sees eleven recessive samples in a row, it counts one bus-idle event and reports a Bit0 code to the last-error-code field. Software can use these reports to follow progress, or to notice a line stuck dominant. On the 129th idle event the block pulses a clear to the transmit and receive error counters and hands the bus back to normal operation.

Software cannot shorten the sequence. Any write to the flag during recovery is discarded. A fresh bus-off restarts the whole count. Bit timing, frame decoding and the error counters themselves live outside this block. All pins are plain control and status signals; there is no data stream, so no valid/ready handshake applies.

Top module: `can_busoff_recovery`

## Requirements
- R1: After reset, `init_flag` is 1, `recov_active` is 0, and neither `lec_wr` nor `errcnt_clr` is asserted.
- R2: Outside bus-off, a write on `init_wr_en` loads `init_wr_data` into `init_flag` on the next cycle. No idle event is reported in that state, whatever the line does.
- R3: A `busoff_evt` pulse sets `init_flag` to 1 on the next cycle, with `recov_active` at 0. Counting starts only after software writes 0 to the flag; `recov_active` then rises on the next cycle. Writing 1 while waiting keeps the block waiting.
- R4: An idle event is eleven consecutive samples with `rx_level` = 1 (recessive), taken only in cycles where `bit_stb` is 1. Cycles without the strobe do not advance the run.
- R5: A sample with `rx_level` = 0 (dominant) restarts the current eleven-sample run. The number of idle events already completed is kept.
- R6: Every idle event asserts `lec_wr` for exactly the cycle of its eleventh recessive sample, with `lec_code` = 3'b101 (the Bit0 code).
- R7: On the 129th idle event, `errcnt_clr` is a one-cycle pulse in the same cycle as that event's `lec_wr`. From the next cycle `recov_active` is 0 and `init_flag` stays 0.
- R8: Writes to the init flag during recovery are ignored. `init_flag` stays 0, and completion still comes after exactly 129 idle events.
- R9: A new `busoff_evt`, even in the middle of recovery, clears the idle-event count and the current run. It takes priority over a write or an idle event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid bit sample |
| rx_level | input | 1 | Sampled bus level, 1 = recessive |
| busoff_evt | input | 1 | One-cycle pulse on entry to bus-off |
| init_wr_en | input | 1 | Software write strobe for the init flag |
| init_wr_data | input | 1 | Value written to the init flag |
| init_flag | output | 1 | Initialization flag; 1 keeps the controller off the bus |
| errcnt_clr | output | 1 | One-cycle clear pulse for the error counters |
| lec_wr | output | 1 | Write strobe for the last-error-code field |
| lec_code | output | 3 | Code to write; always the Bit0 code 3'b101 |
| recov_active | output | 1 | 1 while recovery counting is in progress |

## Verification
The properties assume that `busoff_evt` and `init_wr_en` are single-cycle pulses. They also assume that `rx_level` is meaningful only in cycles where `bit_stb` is high. The directed stimulus changes inputs only one time unit after a rising edge. It raises the strobe for one cycle per sample and issues each bus-off or software write as a single isolated cycle. The long runs that reach the 129th event are therefore free of glitches. Each scenario begins with its own bus-off pulse, so every recovery starts from a cleared count.

// File: rtl/can_bor_pkg.sv
package can_bor_pkg;
  typedef enum logic [1:0] {
    BOR_ONLINE = 2'd0,
    BOR_HOLD   = 2'd1,
    BOR_RECOV  = 2'd2
  } bor_state_e;

  localparam int LEC_W = 3;
  localparam logic [LEC_W-1:0] LEC_BIT0 = 3'b101;
endpackage

// File: rtl/bor_run_detector.sv
module bor_run_detector #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic stb,
  input  logic rx,
  output logic run_done
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q;

  assign run_done = en && stb && rx && (run_q == RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clr || !en) begin
      run_q <= '0;
    end else if (stb) begin
      if (!rx || run_done) run_q <= '0;
      else                 run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/bor_event_counter.sv
module bor_event_counter #(
  parameter int EVENTS = 129,
  parameter int CNT_W  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic last
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EVENTS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bor_ctrl.sv
module bor_ctrl
  import can_bor_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busoff_evt,
  input  logic wr_en,
  input  logic wr_data,
  input  logic done,
  output logic init_flag,
  output logic recov_active
);
  bor_state_e st_q;

  assign recov_active = (st_q == BOR_RECOV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= BOR_ONLINE;
      init_flag <= 1'b1;
    end else if (busoff_evt) begin
      st_q      <= BOR_HOLD;
      init_flag <= 1'b1;
    end else begin
      unique case (st_q)
        BOR_ONLINE: if (wr_en) init_flag <= wr_data;
        BOR_HOLD: if (wr_en && !wr_data) begin
          st_q      <= BOR_RECOV;
          init_flag <= 1'b0;
        end
        BOR_RECOV: if (done) st_q <= BOR_ONLINE;
        default: st_q <= BOR_ONLINE;
      endcase
    end
  end
endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery
  import can_bor_pkg::*;
#(
  parameter int RUN_LEN     = 11,
  parameter int IDLE_EVENTS = 129,
  parameter int IDLE_CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_level,
  input  logic             busoff_evt,
  input  logic             init_wr_en,
  input  logic             init_wr_data,
  output logic             init_flag,
  output logic             errcnt_clr,
  output logic             lec_wr,
  output logic [LEC_W-1:0] lec_code,
  output logic             recov_active
);
  logic run_done;
  logic idle_tick;
  logic idle_last;
  logic done;

  assign idle_tick  = run_done && !busoff_evt;
  assign done       = idle_tick && idle_last;
  assign lec_wr     = idle_tick;
  assign lec_code   = LEC_BIT0;
  assign errcnt_clr = done;

  bor_run_detector #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (busoff_evt),
    .en       (recov_active),
    .stb      (bit_stb),
    .rx       (rx_level),
    .run_done (run_done)
  );

  bor_event_counter #(.EVENTS(IDLE_EVENTS), .CNT_W(IDLE_CNT_W)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (busoff_evt),
    .tick  (idle_tick),
    .last  (idle_last)
  );

  bor_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .busoff_evt   (busoff_evt),
    .wr_en        (init_wr_en),
    .wr_data      (init_wr_data),
    .done         (done),
    .init_flag    (init_flag),
    .recov_active (recov_active)
  );
endmodule

// File: rtl/can_busoff_recovery_chk.sv
module can_busoff_recovery_chk (
  input logic clk,
  input logic rst_n,
  input logic busoff_evt,
  input logic init_wr_en,
  input logic init_wr_data,
  input logic init_flag,
  input logic errcnt_clr,
  input logic lec_wr,
  input logic recov_active
);
  a_r3_busoff_forces_init: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_evt |=> (init_flag && !recov_active));

  a_r3_start_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recov_active) |-> $past(init_wr_en && !init_wr_data && !busoff_evt));

  a_r6_lec_only_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    lec_wr |-> recov_active);

  a_r7_clr_with_lec: assert property (@(posedge clk) disable iff (!rst_n)
    errcnt_clr |-> lec_wr);

  a_r7_clr_ends_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    errcnt_clr |=> (!recov_active && !init_flag && !errcnt_clr));

  a_r8_flag_low_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    recov_active |-> !init_flag);
endmodule

bind can_busoff_recovery can_busoff_recovery_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busoff_evt   (busoff_evt),
  .init_wr_en   (init_wr_en),
  .init_wr_data (init_wr_data),
  .init_flag    (init_flag),
  .errcnt_clr   (errcnt_clr),
  .lec_wr       (lec_wr),
  .recov_active (recov_active)
);

// File: tb/test_can_busoff_recovery.sv
module test_can_busoff_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 11;
  localparam int EVT = 129;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0, rx_level = 1'b1, busoff_evt = 1'b0;
  logic       init_wr_en = 1'b0, init_wr_data = 1'b0;
  logic       init_flag, errcnt_clr, lec_wr, recov_active;
  logic [2:0] lec_code;

  int n_chk = 0, n_bad = 0;
  int lec_seen = 0, clr_seen = 0, clr_alone = 0, bad_code = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_busoff_recovery i_can_busoff_recovery (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_level(rx_level),
    .busoff_evt(busoff_evt), .init_wr_en(init_wr_en), .init_wr_data(init_wr_data),
    .init_flag(init_flag), .errcnt_clr(errcnt_clr), .lec_wr(lec_wr),
    .lec_code(lec_code), .recov_active(recov_active)
  );

  always @(negedge clk) if (rst_n) begin
    if (lec_wr) begin
      lec_seen++;
      if (lec_code !== 3'b101) bad_code++;
    end
    if (errcnt_clr) begin
      clr_seen++;
      if (!lec_wr) clr_alone++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic clear_mon();
    lec_seen = 0; clr_seen = 0; clr_alone = 0; bad_code = 0;
  endtask

  task automatic bits(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      bit_stb = 1'b1; rx_level = lvl;
    end
    @(posedge clk); #1;
    bit_stb = 1'b0; rx_level = 1'b1;
  endtask

  task automatic wr_init(input logic v);
    @(posedge clk); #1;
    init_wr_en = 1'b1; init_wr_data = v;
    @(posedge clk); #1;
    init_wr_en = 1'b0;
  endtask

  task automatic bus_off();
    @(posedge clk); #1;
    busoff_evt = 1'b1;
    @(posedge clk); #1;
    busoff_evt = 1'b0;
  endtask

  task automatic t_reset();
    chk_eq("R1 init_flag", init_flag, 1);
    chk_eq("R1 recov_active", recov_active, 0);
    chk_eq("R1 pulses", int'(lec_wr) + int'(errcnt_clr), 0);
  endtask

  task automatic t_online();
    clear_mon();
    wr_init(1'b0);
    chk_eq("R2 write 0", init_flag, 0);
    bits(40, 1'b1);
    chk_eq("R2 no idle report online", lec_seen, 0);
    wr_init(1'b1);
    chk_eq("R2 write 1", init_flag, 1);
  endtask

  task automatic t_busoff_wait();
    wr_init(1'b0);
    clear_mon();
    bus_off();
    chk_eq("R3 flag forced", init_flag, 1);
    chk_eq("R3 not active", recov_active, 0);
    bits(3 * RUN, 1'b1);
    chk_eq("R3 no count before clear", lec_seen, 0);
    wr_init(1'b1);
    chk_eq("R3 write 1 keeps waiting", recov_active, 0);
    wr_init(1'b0);
    chk_eq("R3 active after clear", recov_active, 1);
    chk_eq("R3 flag cleared", init_flag, 0);
  endtask

  task automatic t_full_recovery();
    clear_mon();
    bus_off();
    wr_init(1'b0);
    bits((EVT - 1) * RUN, 1'b1);
    chk_eq("R4 events counted", lec_seen, EVT - 1);
    chk_eq("R6 code is Bit0", bad_code, 0);
    chk_eq("R7 no early clear", clr_seen, 0);
    bits(RUN - 1, 1'b1);
    chk_eq("R7 still active", recov_active, 1);
    bits(1, 1'b1);
    chk_eq("R7 clear pulse", clr_seen, 1);
    chk_eq("R7 clear with lec", clr_alone, 0);
    chk_eq("R7 done", recov_active, 0);
    chk_eq("R7 flag stays 0", init_flag, 0);
  endtask

  task automatic t_restart_and_strobe();
    clear_mon();
    bus_off();
    wr_init(1'b0);
    bits(RUN - 1, 1'b1);
    bits(1, 1'b0);
    bits(RUN - 1, 1'b1);
    chk_eq("R5 dominant restarts run", lec_seen, 0);
    bits(1, 1'b1);
    chk_eq("R5 run completes", lec_seen, 1);
    bits(5, 1'b1);
    @(posedge clk); #1; rx_level = 1'b1;
    repeat (30) @(posedge clk);
    bits(5, 1'b1);
    chk_eq("R4 no strobe no advance", lec_seen, 1);
    bits(1, 1'b1);
    chk_eq("R4 strobed sample completes", lec_seen, 2);
    bits(3, 1'b1);
    bits(1, 1'b0);
    bits((EVT - 2) * RUN - 1, 1'b1);
    chk_eq("R5 count kept, no clear", clr_seen, 0);
    bits(1, 1'b1);
    chk_eq("R5 completes at 129", clr_seen, 1);
    chk_eq("R5 event total", lec_seen, EVT);
  endtask

  task automatic t_init_ignored();
    clear_mon();
    bus_off();
    wr_init(1'b0);
    bits(50 * RUN, 1'b1);
    wr_init(1'b1);
    chk_eq("R8 write 1 ignored", init_flag, 0);
    chk_eq("R8 still active", recov_active, 1);
    wr_init(1'b0);
    bits((EVT - 50) * RUN - 1, 1'b1);
    chk_eq("R8 not shortened", clr_seen, 0);
    bits(1, 1'b1);
    chk_eq("R8 completes on time", clr_seen, 1);
  endtask

  task automatic t_rebusoff();
    clear_mon();
    bus_off();
    wr_init(1'b0);
    bits(40 * RUN + 4, 1'b1);
    @(posedge clk); #1;
    busoff_evt = 1'b1; init_wr_en = 1'b1; init_wr_data = 1'b0;
    @(posedge clk); #1;
    busoff_evt = 1'b0; init_wr_en = 1'b0;
    chk_eq("R9 bus-off wins over write", init_flag, 1);
    chk_eq("R9 recovery stopped", recov_active, 0);
    wr_init(1'b0);
    clear_mon();
    bits((EVT - 1) * RUN + RUN - 1, 1'b1);
    chk_eq("R9 count restarted", clr_seen, 0);
    bits(1, 1'b1);
    chk_eq("R9 full sequence", clr_seen, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_online();
        t_busoff_wait();
        t_full_recovery();
        t_restart_and_strobe();
        t_init_ignored();
        t_rebusoff();
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule